// File: doc/BRIEF.md
# Control-Table Driven TDM Buffer Fetcher

On each TDM frame-start pulse this block scans a table of 32-bit control words held in external memory. Each word that is marked valid points at a receive circular buffer elsewhere in the same memory. The block reads the next byte of that buffer and copies it into an internal frame memory slot. The slot is selected by the stream and channel numbers held in the word. After each move the block may overwrite the buffer byte with the silence code FFh. If the receive side has written no new byte since the last read, the block flags an underrun.

The block keeps one read offset for each table entry. The offset wraps at the buffer size. The buffer size and the buffer base are packed together into one aligned field of the control word. A scan that is still running four frame-starts after it began raises a sticky out-of-bandwidth error. Both status bits are sticky and are cleared by writing one to a clear input. They can be combined into a single interrupt line.

All external memory traffic uses a request/acknowledge handshake with one request in flight at a time.

Top module: `tdm_fetch_top`

## Requirements
- R1: After reset, mem_req, fm_we, irq and both status bits are 0, and every per-entry read offset is 0.
- R2: A scan starts on a frame_start pulse only when no scan is running. Entry i is read as a 32-bit word at address tbl_base + 4*i, for i from 0 to tbl_count-1 in increasing order. When tbl_count is 0, no memory access and no frame memory write takes place.
- R3: An entry whose bit 15 is 0 causes no byte read, no frame memory write and no write-back, and its read offset is left unchanged. The scan continues with the next entry.
- R4: For a valid entry, the byte that is fetched is written to frame memory at fm_addr = entry bits 10:0. Bits 10:4 give the channel and bits 3:0 give the stream. Bits 12:11 are ignored.
- R5: Entry bits 31:16 form a location field. Let p be the index of the lowest set bit among field bits 3:0, or p = 4 when those four bits are all zero. The buffer size is 64<<p bytes. The buffer base is {field[15:1], 6'b0} with its lowest 6+p bits forced to zero.
- R6: The byte address is the buffer base plus the entry's read offset. Each time a valid entry is processed, its offset advances by one modulo the buffer size.
- R7: When entry bit 14 is 0, the byte address is written with data FFh after the frame memory write. When bit 14 is 1, no memory write is made.
- R8: When entry bit 13 is 1 and the read offset equals woff_val masked to the buffer size, status bit 0 (underrun) is set. woff_val is sampled while woff_idx shows the entry index. This check does not depend on bit 14.
- R9: Status bit 1 (out-of-bandwidth) is set when a fourth frame_start arrives while the scan that began at an earlier frame_start is still running.
- R10: Status bits are sticky. Pulsing bit k of sts_clr clears status bit k on the next cycle. irq equals the OR of (status AND irq_en).
- R11: While mem_req is high and mem_ack is low, mem_req stays high and mem_addr, mem_we and mem_wdata stay stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle frame-start pulse |
| tbl_base | input | 21 | Byte address of table entry 0 |
| tbl_count | input | 5 | Number of table entries (0 to 16) |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 21 | External memory byte address |
| mem_wdata | output | 32 | Write data (FFh in the low byte) |
| mem_rdata | input | 32 | Read data; bytes are returned in bits 7:0 |
| mem_ack | input | 1 | Request accepted; read data valid |
| fm_we | output | 1 | Frame memory write strobe |
| fm_addr | output | 11 | Frame memory slot {channel, stream} |
| fm_data | output | 8 | Byte written to frame memory |
| woff_idx | output | 4 | Entry index for the write-offset lookup |
| woff_val | input | 10 | Receive write offset for entry woff_idx |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| irq_en | input | 2 | Interrupt enable per status bit |
| sts | output | 2 | Bit 0 underrun, bit 1 out-of-bandwidth |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs one 64-byte buffer past its wrap point. A design that did not write back would then return the original byte instead of FFh, and one that wrapped at the wrong place would read from outside the buffer. Invalid entries sit in the middle of the table, where any fetch or offset change on them would misalign the expected transaction stream. Underrun is made to occur at one exact frame on a write-back-disabled entry. The bandwidth limit is probed on both sides: three frame-starts during a scan must not set the error, and four must. A zero-length table must produce no traffic at all.

// File: rtl/tdm_fetch_pkg.sv
// Shared types for the TDM buffer fetcher.
// Assumes the fixed 32-bit control word layout and a 21-bit byte address space.
package tdm_fetch_pkg;
    localparam int ADDR_W = 21;
    localparam int OFF_W  = 10;

    typedef enum logic [2:0] {
        S_IDLE, S_ENT, S_CHK, S_BYTE, S_FM, S_WB, S_NEXT
    } fetch_state_t;

    typedef struct packed {
        logic [15:0] loc;
        logic        valid;
        logic        keep;
        logic        ur_en;
        logic [1:0]  rsvd;
        logic [6:0]  chan;
        logic [3:0]  strm;
    } ctl_word_t;
endpackage

// File: rtl/tdm_fetch_locdec.sv
// Decodes the packed location field into buffer base address and size mask.
// Assumes the lowest set bit among field bits 3:0 marks the size; none set means 1024 bytes.
module tdm_fetch_locdec
    import tdm_fetch_pkg::*;
(
    input  logic [15:0]       loc,
    output logic [ADDR_W-1:0] base,
    output logic [OFF_W-1:0]  mask
);
    logic [2:0] p;

    // Finds the marker bit position.
    always_comb begin
        p = 3'd4;
        for (int k = 3; k >= 0; k--) begin
            if (loc[k]) p = 3'(k);
        end
    end

    // Builds the size mask and the aligned base.
    always_comb begin
        mask = OFF_W'((64 << p) - 1);
        base = {loc[15:1], 6'b0} & ~{{(ADDR_W-OFF_W){1'b0}}, mask};
    end
endmodule

// File: rtl/tdm_fetch_offs.sv
// Stores one circular-buffer read offset per table entry.
// Assumes one read port and one write port; writes take effect on the next cycle.
module tdm_fetch_offs
    import tdm_fetch_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [OFF_W-1:0]  rd_off,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off
);
    logic [OFF_W-1:0] offs [DEPTH];

    // Holds the offsets; reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) offs[i] <= '0;
        end else if (wr_en) begin
            offs[wr_idx] <= wr_off;
        end
    end

    assign rd_off = offs[rd_idx];
endmodule

// File: rtl/tdm_fetch_status.sv
// Sticky status bits, frame-start deadline counter and interrupt combine.
// Assumes scan_start and busy come from the scan sequencer; set wins over clear.
module tdm_fetch_status #(
    parameter int DEADLINE = 4,
    localparam int DL_W = $clog2(DEADLINE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       scan_start,
    input  logic       busy,
    input  logic       ur_hit,
    input  logic [1:0] sts_clr,
    input  logic [1:0] irq_en,
    output logic [1:0] sts,
    output logic       irq
);
    logic [DL_W-1:0] fs_cnt;
    logic            late;

    assign late = busy && frame_start && (fs_cnt == DL_W'(DEADLINE - 1));

    // Counts frame-starts seen while the current scan is still running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                fs_cnt <= '0;
        else if (scan_start)                       fs_cnt <= '0;
        else if (busy && frame_start && fs_cnt != DL_W'(DEADLINE))
                                                   fs_cnt <= fs_cnt + 1'b1;
    end

    // Sticky status with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts[0] <= ur_hit | (sts[0] & ~sts_clr[0]);
            sts[1] <= late   | (sts[1] & ~sts_clr[1]);
        end
    end

    assign irq = |(sts & irq_en);

    AST_OOB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[1] && !sts_clr[1]) |=> sts[1]); // R10
    AST_UR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !sts_clr[0]) |=> sts[0]); // R10
endmodule

// File: rtl/tdm_fetch_top.sv
// Walks the control table once per frame, moves one byte per valid entry
// into frame memory, optionally writes silence back and checks underrun.
// Assumes mem_ack is a single-cycle response to a held request.
module tdm_fetch_top
    import tdm_fetch_pkg::*;
#(
    parameter int MAX_ENT  = 16,
    parameter int DEADLINE = 4,
    localparam int IDX_W = $clog2(MAX_ENT),
    localparam int CNT_W = $clog2(MAX_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [CNT_W-1:0]  tbl_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              fm_we,
    output logic [10:0]       fm_addr,
    output logic [7:0]        fm_data,
    output logic [IDX_W-1:0]  woff_idx,
    input  logic [OFF_W-1:0]  woff_val,
    input  logic [1:0]        sts_clr,
    input  logic [1:0]        irq_en,
    output logic [1:0]        sts,
    output logic              irq
);
    fetch_state_t      state;
    ctl_word_t         ent_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        byte_q;
    logic [ADDR_W-1:0] buf_base;
    logic [OFF_W-1:0]  buf_mask;
    logic [OFF_W-1:0]  cur_off;
    logic              scan_start;
    logic              ur_hit;
    logic              off_wr;
    logic              last_ent;

    tdm_fetch_locdec u_dec (
        .loc  (ent_q.loc),
        .base (buf_base),
        .mask (buf_mask)
    );

    tdm_fetch_offs #(.DEPTH(MAX_ENT)) u_offs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (idx_q),
        .rd_off (cur_off),
        .wr_en  (off_wr),
        .wr_idx (idx_q),
        .wr_off ((cur_off + 1'b1) & buf_mask)
    );

    tdm_fetch_status #(.DEADLINE(DEADLINE)) u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .scan_start  (scan_start),
        .busy        (state != S_IDLE),
        .ur_hit      (ur_hit),
        .sts_clr     (sts_clr),
        .irq_en      (irq_en),
        .sts         (sts),
        .irq         (irq)
    );

    assign scan_start = (state == S_IDLE) && frame_start && (tbl_count != '0);
    assign off_wr     = (state == S_CHK) && ent_q.valid;
    assign ur_hit     = off_wr && ent_q.ur_en && ((cur_off & buf_mask) == (woff_val & buf_mask));
    assign last_ent   = (CNT_W'(idx_q) + 1'b1) == cnt_q;
    assign woff_idx   = idx_q;

    // Scan sequencer: entry fetch, byte fetch, frame write, write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            ent_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            addr_q <= '0;
            byte_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (scan_start) begin
                    idx_q <= '0;
                    cnt_q <= tbl_count;
                    state <= S_ENT;
                end
                S_ENT: if (mem_ack) begin
                    ent_q <= mem_rdata;
                    state <= S_CHK;
                end
                S_CHK: begin
                    addr_q <= buf_base | ADDR_W'(cur_off & buf_mask);
                    state  <= ent_q.valid ? S_BYTE : S_NEXT;
                end
                S_BYTE: if (mem_ack) begin
                    byte_q <= mem_rdata[7:0];
                    state  <= S_FM;
                end
                S_FM:   state <= ent_q.keep ? S_NEXT : S_WB;
                S_WB:   if (mem_ack) state <= S_NEXT;
                S_NEXT: begin
                    if (last_ent) state <= S_IDLE;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        state <= S_ENT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drives the memory request and frame-memory write from the state.
    always_comb begin
        mem_req   = (state == S_ENT) || (state == S_BYTE) || (state == S_WB);
        mem_we    = (state == S_WB);
        mem_addr  = (state == S_ENT) ? tbl_base + {idx_q, 2'b00} : addr_q;
        mem_wdata = (state == S_WB) ? 32'h0000_00FF : 32'h0;
        fm_we     = (state == S_FM);
        fm_addr   = {ent_q.chan, ent_q.strm};
        fm_data   = byte_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!mem_req && !fm_we)); // R2
    AST_WB_AFTER_FM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(fm_we)); // R7
    AST_SKIP_NO_FM: assert property (@(posedge clk) disable iff (!rst_n)
        fm_we |-> ent_q.valid); // R3
endmodule

// File: tb/tdm_fetch_top_test.sv
module tdm_fetch_top_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        frame_start = 0;
    logic [20:0] tbl_base = 21'h1000;
    logic [4:0]  tbl_count = 0;
    logic        mem_req, mem_we, fm_we, irq;
    logic [20:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 0;
    logic        mem_ack = 0;
    logic [10:0] fm_addr;
    logic [7:0]  fm_data;
    logic [3:0]  woff_idx;
    logic [9:0]  woff_val;
    logic [1:0]  sts_clr = 0, irq_en = 0, sts;

    int total = 0, bad = 0;
    bit chk_data = 1;
    int fm_cnt = 0, req_cnt = 0;
    bit done = 0;

    logic [31:0] tbl [int];
    logic [7:0]  bmem [int];
    logic [7:0]  emem [int];
    int          moff [16];
    logic [9:0]  woff_arr [16];
    int          exp_fm [$];
    int          exp_wb [$];
    bit          exp_ur = 0;

    always #2.5 clk = ~clk;

    tdm_fetch_top uut (.*);

    assign woff_val = woff_arr[woff_idx];

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // Builds a control word: size code p, aligned base, flags, channel, stream.
    function automatic logic [31:0] mk(int base, int p, bit v, bit keep, bit ur, int ch, int st);
        int fld;
        fld = ((base >> (6 + p)) << (p + 1)) | (1 << p);
        return {16'(fld), v, keep, ur, 2'b11, 7'(ch), 4'(st)};
    endfunction

    // Memory responder: one-cycle ack per held request.
    always @(posedge clk) begin
        mem_ack <= 0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1;
            if (tbl.exists(int'(mem_addr)))       mem_rdata <= tbl[int'(mem_addr)];
            else if (bmem.exists(int'(mem_addr))) mem_rdata <= {24'b0, bmem[int'(mem_addr)]};
            else                                  mem_rdata <= {24'b0, dflt(int'(mem_addr))};
            if (mem_we) bmem[int'(mem_addr)] = mem_wdata[7:0];
        end
    end

    // Reference model: expected transactions of one full scan.
    task automatic model_scan(int base, int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            int fld, p, size, bb, a;
            logic [7:0] d;
            w = tbl[base + 4 * i];
            if (!w[15]) continue;                         // R3
            fld = int'(w[31:16]);
            p = 4;
            for (int k = 3; k >= 0; k--) if (fld[k]) p = k;
            size = 64 << p;                               // R5
            bb = (fld >> (p + 1)) << (6 + p);
            a = bb + moff[i];                             // R6
            d = emem.exists(a) ? emem[a] : dflt(a);
            exp_fm.push_back({int'(w[10:0]), 8'(d)});     // R4
            if (!w[14]) begin
                exp_wb.push_back(a);                      // R7
                emem[a] = 8'hFF;
            end
            if (w[13] && (moff[i] == (int'(woff_arr[i]) & (size - 1)))) exp_ur = 1; // R8
            moff[i] = (moff[i] + 1) % size;
        end
    endtask

    // Per-clock comparison of frame writes, write-backs and request hold.
    logic        pend = 0;
    logic [20:0] pend_a;
    logic        pend_w;
    always @(negedge clk) if (rst_n) begin
        if (pend) chk(mem_req && mem_addr == pend_a && mem_we == pend_w, "R11 hold", int'(mem_addr), int'(pend_a));
        pend = mem_req && !mem_ack; pend_a = mem_addr; pend_w = mem_we;
        if (mem_req && !mem_ack) req_cnt++;
        if (fm_we) begin
            fm_cnt++;
            if (chk_data) begin
                if (exp_fm.size() == 0) chk(0, "R3 unexpected fm write", int'(fm_addr), 0);
                else begin
                    int e;
                    e = exp_fm.pop_front();
                    chk({fm_addr, fm_data} == 19'(e), "R4 fm slot/data", int'({fm_addr, fm_data}), e);
                end
            end
        end
        if (mem_req && mem_we && mem_ack && chk_data) begin
            if (exp_wb.size() == 0) chk(0, "R7 unexpected write-back", int'(mem_addr), 0);
            else begin
                int e;
                e = exp_wb.pop_front();
                chk(int'(mem_addr) == e && mem_wdata[7:0] == 8'hFF, "R7 write-back", int'(mem_addr), e);
            end
        end
    end

    task automatic pulse_fs();
        @(negedge clk) frame_start = 1;
        @(negedge clk) frame_start = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 16; i++) moff[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) woff_arr[i] = 10'h3FF;
        // Main table at 0x1000.
        tbl[21'h1000] = mk(21'h10000, 0, 1, 0, 0, 5, 3);
        tbl[21'h1004] = mk(21'h20080, 1, 1, 1, 1, 127, 15);
        tbl[21'h1008] = mk(21'h30000, 0, 0, 0, 1, 9, 1);
        tbl[21'h100C] = mk(21'h1FC00, 4, 1, 0, 1, 0, 0);
        tbl[21'h1010] = mk(21'h40100, 2, 1, 1, 0, 64, 8);
        woff_arr[1] = 10'd5;
        woff_arr[3] = 10'd700;
        // Bandwidth table at 0x2000.
        for (int i = 0; i < 8; i++) tbl[21'h2000 + 4 * i] = mk(21'h50000 + 64 * i, 0, 1, 0, 0, i, 2);

        do_reset();
        @(negedge clk);
        chk(!mem_req && !fm_we, "R1 reset idle", int'({mem_req, fm_we}), 0);
        chk(sts == 0 && irq == 0, "R1 reset status", int'({sts, irq}), 0);

        // Empty table: no traffic.
        tbl_count = 0;
        pulse_fs();
        repeat (30) @(negedge clk);
        chk(req_cnt == 0 && fm_cnt == 0, "R2 empty table", req_cnt + fm_cnt, 0);

        // Main run: 70 frames, past the 64-byte wrap.
        tbl_count = 5;
        irq_en = 2'b01;
        for (int f = 0; f < 70; f++) begin
            model_scan(21'h1000, 5);
            pulse_fs();
            repeat (80) @(negedge clk);
            chk(sts[0] == exp_ur, "R8 underrun", int'(sts[0]), int'(exp_ur));
            chk(irq == exp_ur, "R10 irq", int'(irq), int'(exp_ur));
            if (sts[0]) begin
                @(negedge clk) sts_clr = 2'b01;
                @(negedge clk) sts_clr = 2'b00;
                chk(sts[0] == 0, "R10 clear", int'(sts[0]), 0);
                exp_ur = 0;
            end
        end
        chk(exp_fm.size() == 0 && exp_wb.size() == 0, "R6 queues drained", exp_fm.size() + exp_wb.size(), 0);
        chk(fm_cnt == 70 * 4, "R3 fm count", fm_cnt, 280);
        chk(sts[1] == 0, "R9 no oob in normal run", int'(sts[1]), 0);

        // Three frame-starts during a scan: no error, second scan only after end.
        chk_data = 0;
        do_reset();
        tbl_base = 21'h2000;
        tbl_count = 4;
        fm_cnt = 0;
        irq_en = 2'b10;
        for (int k = 0; k < 5; k++) begin
            pulse_fs();
            repeat (8) @(negedge clk);
        end
        repeat (100) @(negedge clk);
        chk(sts[1] == 0, "R9 three pending starts", int'(sts[1]), 0);
        chk(fm_cnt == 8, "R2 no restart while busy", fm_cnt, 8);

        // Four frame-starts during a scan: error.
        tbl_count = 8;
        for (int k = 0; k < 5; k++) begin
            pulse_fs();
            repeat (8) @(negedge clk);
        end
        repeat (200) @(negedge clk);
        chk(sts[1] == 1, "R9 oob set", int'(sts[1]), 1);
        chk(irq == 1, "R10 irq on oob", int'(irq), 1);
        @(negedge clk) sts_clr = 2'b10;
        @(negedge clk) sts_clr = 2'b00;
        chk(sts[1] == 0 && irq == 0, "R10 oob clear", int'({sts[1], irq}), 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule